// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces memory addresses for indirect data accesses. It keeps a small file of pointer registers, a matching file of signed step values and a file of buffer lengths. On every access the selected pointer is presented as the address. In the same cycle the pointer is advanced by the selected step.

When the length paired with that pointer is non-zero, the advance wraps inside a circular buffer. The buffer starts at the pointer with its low bits cleared, at the granularity of the smallest power of two that is not below the length, and it spans exactly that length. A length of zero gives plain linear stepping that wraps around the full address space.

A build-time option reverses the bit order of the presented address. This serves as the addressing for FFT data reordering. Only one of the two intended instances turns it on. The stored pointers are never reversed.

Top module: `dag_circ`

## Requirements
- R1: While `rst_n` is low, and after it rises, every pointer, step and length register is zero, `addr_vld` is 0 and `addr_out` is 0.
- R2: An access (`acc_en`=1) on a clock edge makes `addr_vld` 1 after that edge and shows the pre-update value of pointer `acc_isel` on `addr_out`. A cycle with no access leaves `addr_vld` at 0 and `addr_out` unchanged.
- R3: After an access, pointer `acc_isel` has advanced by step `acc_msel`, which is read as a signed 14-bit two's-complement number. Pointers that are not accessed and not written keep their value.
- R4: With a length of 0, the advance is linear modulo 2^14. For example, 16380 with step +5 gives 1.
- R5: With a length L of 1 or more, let P be the smallest power of two that is at least L, and let the base be the pointer rounded down to a multiple of P. For a positive step smaller than L, a pointer inside [base, base+L) stays inside that window, and L is subtracted when the sum reaches base+L.
- R6: For a negative step whose magnitude is smaller than L, L is added when the sum falls below the base, so the pointer stays inside [base, base+L).
- R7: With parameter `BITREV`=1, bit k of `addr_out` equals bit 13-k of the stored address, and the pointer update is unchanged. With `BITREV`=0, the address is passed through unchanged.
- R8: A register write to pointer n in the same cycle as an access to pointer n stores the written data, not the advanced value. The address shown for that access is still the old pointer.
- R9: A write (`wr_en`=1) uses `wr_sel` to choose the register file: 0 for pointers, 1 for steps, 2 for lengths. `wr_idx` picks the entry. `wr_sel`=3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register file select: 0 pointer, 1 step, 2 length, 3 none |
| wr_idx | input | 2 | Entry within the selected file |
| wr_data | input | 14 | Data to write |
| acc_en | input | 1 | Access strobe |
| acc_isel | input | 2 | Pointer used by the access |
| acc_msel | input | 2 | Step used by the access |
| addr_out | output | 14 | Registered address, bit-reversed when BITREV=1 |
| addr_vld | output | 1 | High the cycle after an access |

## Verification
The generator is driven with several patterns. Linear stepping near the top of the address space shows whether the full-width wrap happens when the length is zero. Forward and backward steps through buffers whose lengths are not powers of two separate a correct base-and-length window from a power-of-two mask. A write that collides with an access on the same pointer tells write priority apart from update priority. A write with the unused select, and idle cycles between accesses, show that no register changes and that the valid flag drops. Two instances, one with bit reversal and one without, receive the same stimulus. Both are compared every cycle against a behavioural integer model.

// File: rtl/dag_pkg.sv
package dag_pkg;
    localparam int DAG_AW   = 14;
    localparam int DAG_NPTR = 4;

    typedef enum logic [1:0] {
        SEL_IDX  = 2'd0,
        SEL_MOD  = 2'd1,
        SEL_LEN  = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;
endpackage

// File: rtl/dag_modulo.sv
module dag_modulo #(
    parameter int AW = 14
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] mdf,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] nxt
);
    localparam int WW = AW + 2;

    logic [AW-1:0]        mask;
    logic [AW-1:0]        base;
    logic signed [WW-1:0] s_sum;
    logic signed [WW-1:0] s_base;
    logic signed [WW-1:0] s_top;
    logic signed [WW-1:0] s_len;
    logic signed [WW-1:0] s_mdf;
    logic signed [WW-1:0] s_res;

    // smear the top set bit of len-1 downward to get P-1
    always_comb begin
        mask = len - AW'(1);
        for (int k = 1; k < AW; k = k * 2) begin
            mask = mask | (mask >> k);
        end
        if (len == '0) mask = '0;
    end

    always_comb begin
        base   = ptr & ~mask;
        s_mdf  = WW'(signed'(mdf));
        s_len  = signed'({2'b00, len});
        s_base = signed'({2'b00, base});
        s_top  = s_base + s_len;
        s_sum  = signed'({2'b00, ptr}) + s_mdf;
        if (len == '0)         s_res = s_sum;
        else if (s_sum >= s_top) s_res = s_sum - s_len;
        else if (s_sum < s_base) s_res = s_sum + s_len;
        else                   s_res = s_sum;
        nxt = s_res[AW-1:0];
    end

    // R5 R6: in-window pointer with small step stays in window
    always_comb begin
        if (len != '0 && {2'b00, ptr} >= s_base && signed'({2'b00, ptr}) < s_top
            && s_mdf < s_len && -s_mdf < s_len) begin
            circ_range_chk: assert (signed'({2'b00, nxt}) >= s_base
                                    && signed'({2'b00, nxt}) < s_top)
                else $error("pointer left circular window");
        end
    end
endmodule

// File: rtl/dag_bitrev.sv
module dag_bitrev #(
    parameter int AW     = 14,
    parameter bit ENABLE = 1'b0
) (
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout
);
    generate
        if (ENABLE) begin : g_rev
            for (genvar b = 0; b < AW; b++) begin : g_bit
                assign dout[b] = din[AW-1-b];
            end
        end else begin : g_pass
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/dag_circ.sv
module dag_circ
    import dag_pkg::*;
#(
    parameter int AW     = DAG_AW,
    parameter int NPTR   = DAG_NPTR,
    parameter bit BITREV = 1'b0,
    localparam int SW    = $clog2(NPTR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [SW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic          acc_en,
    input  logic [SW-1:0] acc_isel,
    input  logic [SW-1:0] acc_msel,
    output logic [AW-1:0] addr_out,
    output logic          addr_vld
);
    typedef struct packed {
        logic [NPTR-1:0][AW-1:0] idx;
        logic [NPTR-1:0][AW-1:0] mdf;
        logic [NPTR-1:0][AW-1:0] len;
        logic [AW-1:0]           addr;
        logic                    vld;
    } st_t;

    st_t           st_d, st_q;
    logic [AW-1:0] upd_ptr;

    dag_modulo #(.AW(AW)) i_mod (
        .ptr (st_q.idx[acc_isel]),
        .mdf (st_q.mdf[acc_msel]),
        .len (st_q.len[acc_isel]),
        .nxt (upd_ptr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = acc_en;
        if (acc_en) begin
            st_d.addr          = st_q.idx[acc_isel];
            st_d.idx[acc_isel] = upd_ptr;
        end
        // write after access: write wins on collision
        if (wr_en) begin
            unique case (wsel_e'(wr_sel))
                SEL_IDX:  st_d.idx[wr_idx] = wr_data;
                SEL_MOD:  st_d.mdf[wr_idx] = wr_data;
                SEL_LEN:  st_d.len[wr_idx] = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dag_bitrev #(.AW(AW), .ENABLE(BITREV)) i_rev (
        .din  (st_q.addr),
        .dout (addr_out)
    );
    assign addr_vld = st_q.vld;

    // R2
    vld_follows_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> addr_vld);
    // R2
    idle_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> (!addr_vld && $stable(addr_out)));
    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !wr_en) |=> $stable(st_q.idx));
    // R8
    write_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && wr_en && wr_sel == 2'd0 && wr_idx == acc_isel)
        |=> st_q.idx[$past(acc_isel)] == $past(wr_data));
endmodule

// File: tb/test_dag_circ.sv
`timescale 1ns/1ps
module test_dag_circ;
    localparam int AW = 14;
    localparam int AMAX = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [1:0]    wr_idx = '0;
    logic [AW-1:0] wr_data = '0;
    logic          acc_en = 1'b0;
    logic [1:0]    acc_isel = '0;
    logic [1:0]    acc_msel = '0;
    logic [AW-1:0] addr_a, addr_b;
    logic          vld_a, vld_b;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    bit done = 0;

    always #10 clk = ~clk;

    dag_circ #(.BITREV(1'b0)) i_dag_circ (
        .clk, .rst_n, .wr_en, .wr_sel, .wr_idx, .wr_data,
        .acc_en, .acc_isel, .acc_msel, .addr_out(addr_a), .addr_vld(vld_a));

    dag_circ #(.BITREV(1'b1)) i_dag_circ_rev (
        .clk, .rst_n, .wr_en, .wr_sel, .wr_idx, .wr_data,
        .acc_en, .acc_isel, .acc_msel, .addr_out(addr_b), .addr_vld(vld_b));

    // behavioural model
    int m_i[4], m_m[4], m_l[4];
    int e_addr = 0;
    bit e_vld = 0;

    function automatic int rev14(int v);
        int r = 0;
        for (int b = 0; b < AW; b++) if (v[b]) r = r | (1 << (AW - 1 - b));
        return r;
    endfunction

    function automatic int step(int p, int s, int len);
        int ss = (s >= AMAX / 2) ? s - AMAX : s;
        int sum = p + ss;
        if (len == 0) return ((sum % AMAX) + AMAX) % AMAX;
        begin
            int pw = 1;
            int base;
            while (pw < len) pw = pw * 2;
            base = p - (p % pw);
            if (sum >= base + len) sum = sum - len;
            else if (sum < base) sum = sum + len;
        end
        return ((sum % AMAX) + AMAX) % AMAX;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) begin m_i[k] = 0; m_m[k] = 0; m_l[k] = 0; end
            e_addr = 0; e_vld = 0;
        end else begin
            e_vld = acc_en;
            if (acc_en) begin
                e_addr = m_i[acc_isel];
                m_i[acc_isel] = step(m_i[acc_isel], m_m[acc_msel], m_l[acc_isel]);
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_i[wr_idx] = int'(wr_data);
                    2'd1: m_m[wr_idx] = int'(wr_data);
                    2'd2: m_l[wr_idx] = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (int'(addr_a) != e_addr || vld_a != e_vld) begin
                errors++;
                $display("FAIL %s plain: addr=%0d vld=%0b expected addr=%0d vld=%0b",
                         cur_req, addr_a, vld_a, e_addr, e_vld);
            end
            checks++;
            if (int'(addr_b) != rev14(e_addr) || vld_b != e_vld) begin
                errors++;
                $display("FAIL %s R7 reversed: addr=%0d vld=%0b expected addr=%0d vld=%0b",
                         cur_req, addr_b, vld_b, rev14(e_addr), e_vld);
            end
        end
    end

    task automatic cyc(bit we, int ws, int wi, int wd, bit ae, int ai, int am);
        @(negedge clk);
        #1;
        wr_en = we; wr_sel = 2'(ws); wr_idx = 2'(wi); wr_data = AW'(wd);
        acc_en = ae; acc_isel = 2'(ai); acc_msel = 2'(am);
    endtask

    task automatic wr(int ws, int wi, int wd);
        cyc(1, ws, wi, wd, 0, 0, 0);
    endtask

    task automatic acc(int ai, int am, int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 1, ai, am);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        // R1 reset state
        cur_req = "R1";
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        acc(0, 0, 1); // R1: pointer 0 reads back zero
        idle(2);
        // R9 write encoding, sel 3 ignored; R2 R3 basic access
        cur_req = "R9";
        wr(0, 0, 100); wr(1, 0, 3); wr(2, 0, 0);
        wr(3, 0, 555); wr(3, 1, 777);
        cur_req = "R2";
        acc(0, 0, 3);
        idle(2);
        cur_req = "R3";
        acc(0, 0, 1); idle(1); acc(0, 0, 2);
        // R4 linear wrap
        cur_req = "R4";
        wr(0, 1, 16380); wr(1, 1, 5);
        acc(1, 1, 4);
        // R5 circular forward, L=10 base 16
        cur_req = "R5";
        wr(0, 2, 18); wr(2, 2, 10); wr(1, 2, 4);
        acc(2, 2, 8);
        wr(1, 2, 9);
        acc(2, 2, 5);
        // R6 circular backward, L=5 base 32
        cur_req = "R6";
        wr(0, 3, 35); wr(2, 3, 5); wr(1, 3, 16381);
        acc(3, 3, 8);
        acc(3, 2, 1); // step 9 >= L out of contract, model still compared
        wr(0, 3, 33); wr(1, 3, 16383);
        acc(3, 3, 4);
        // R7 single bits for the reversed instance
        cur_req = "R7";
        wr(0, 0, 1); wr(1, 0, 2);
        acc(0, 0, 6);
        // R8 collision
        cur_req = "R8";
        cyc(1, 0, 2, 20, 1, 2, 2);
        acc(2, 2, 2);
        cyc(1, 0, 1, 7, 1, 2, 2); // different pointer: both take effect
        acc(1, 1, 1); acc(2, 2, 1);
        idle(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule